// File: doc/BRIEF.md
# Three-Wire Configuration Word Receiver

This block receives 16-bit configuration words over three slow control wires (a control clock, a data line and a latch strobe) and loads each complete word into one of three configuration registers. The left and right channel registers each hold a 13-bit volume value and a mute flag. The mode register holds the serial audio format, the word length, the sample-rate select and the de-emphasis curve. The receiver does no ramping of volume changes. A downstream block does that from the registered values.

All three control wires are asynchronous to the system clock `clk`. Each one passes through a synchroniser, and the control clock and the latch are then edge-detected in the `clk` domain. The control clock may stop between bits for any length of time. Data is shifted most significant bit first. A word takes effect only when a latch rising edge arrives after at least 16 bits. Every control-wire level, high or low, must last at least three `clk` cycles.

The block has no streamed data path, so it has no valid/ready handshake. Every pin is a plain level, and the outputs are register values that are valid in every cycle after reset.

Top module: `cfgp_port`

## Requirements
- R1: While `rst` is high, and after it falls, the outputs hold their defaults until a word is committed. Both volumes are 13'h1FFF with mute at 0. The mode fields are `fmt_sel`=01 (I2S), `word_len`=11 (24-bit), `rate_sel`=00 and `deemph_sel`=00 (off).
- R2: `ctl_data` is sampled on each rising edge of `ctl_clk` and shifted in most significant bit first. Bit 15 of the committed word is the first bit of the last 16 bits shifted.
- R3: Shifting alone never changes an output. A word is committed only on a rising edge of `ctl_latch`, and only if 16 or more bits have been shifted since the previous latch or reset. The outputs update within 5 `clk` cycles of that edge.
- R4: Word bits [15:14]=00 write the left channel. Bit 13 goes to `left_mute` and bits [12:0] go to `left_vol`. The right channel and the mode fields are unchanged.
- R5: Word bits [15:14]=01 write the right channel in the same way, through `right_mute` and `right_vol`. The other registers are unchanged.
- R6: Word bits [15:14]=10 write the mode register. Bits [1:0] go to `fmt_sel`, [3:2] to `word_len`, [5:4] to `rate_sel` and [7:6] to `deemph_sel`. Bits [13:8] are ignored, and the volume registers are unchanged.
- R7: A committed word with bits [15:14]=11 changes no output.
- R8: A latch edge that arrives after fewer than 16 bits changes no output. Every latch edge clears the bit count, so bits shifted before a latch never count toward the next word.
- R9: If more than 16 bits are shifted before a latch, only the last 16 are used.
- R10: Idle gaps of any length between control clock pulses do not disturb reception.
- R11: Raising `rst` at any point, including partway through a word, restores the R1 defaults and discards the partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| ctl_clk | input | 1 | Control clock, may be gated |
| ctl_data | input | 1 | Control data, MSB first |
| ctl_latch | input | 1 | Commit strobe; a rising edge commits the word |
| left_vol | output | 13 | Left channel volume |
| left_mute | output | 1 | Left channel mute |
| right_vol | output | 13 | Right channel volume |
| right_mute | output | 1 | Right channel mute |
| fmt_sel | output | 2 | Serial format: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP |
| word_len | output | 2 | Word length: 00 16-bit, 01 18-bit, 10 20-bit, 11 24-bit |
| rate_sel | output | 2 | Sample-rate select |
| deemph_sel | output | 2 | De-emphasis: 00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz |

## Verification
The words in the vector table have asymmetric bit patterns, so a reversed bit order or a shifted address field produces a wrong register value. Each word is checked against every output at once, which separates writes to the left, right and mode registers from the reserved address and exposes any leak between registers.

Directed sequences cover the remaining cases:
- Shifting without a latch, then a latch on its own, separates commit-on-latch from commit-on-count.
- A 10-bit burst followed by a 6-bit burst separates a bit count that clears at the latch from one that accumulates.
- A 20-bit burst shows that the oldest bits are dropped.
- A word sent with long gaps between bits, and a reset in the middle of a word, show that reception does not depend on clock continuity and that reset discards the partial word.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 2;
  localparam int PAY_W  = WORD_W - ADDR_W;
  localparam int VOL_W  = PAY_W - 1;
  localparam int FLD_W  = 2;
  localparam int MODE_W = 4 * FLD_W;

  typedef enum logic [ADDR_W-1:0] {
    DST_LEFT  = 2'b00,
    DST_RIGHT = 2'b01,
    DST_MODE  = 2'b10,
    DST_RSVD  = 2'b11
  } dest_e;

  typedef struct packed {
    logic [FLD_W-1:0] deemph;
    logic [FLD_W-1:0] rate;
    logic [FLD_W-1:0] wlen;
    logic [FLD_W-1:0] fmt;
  } mode_t;

  typedef struct packed {
    logic             mute;
    logic [VOL_W-1:0] vol;
  } chan_t;

  localparam chan_t CHAN_DEFAULT = '{mute: 1'b0, vol: '1};
  localparam mode_t MODE_DEFAULT = '{deemph: 2'b00, rate: 2'b00, wlen: 2'b11, fmt: 2'b01};
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfgp_rise.sv
module cfgp_rise (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/cfgp_shifter.sv
module cfgp_shifter #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic             latch,
  output logic [W-1:0]     word,
  output logic [CNT_W-1:0] count,
  output logic             commit
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0]     sr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (latch) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      sr_q  <= {sr_q[W-2:0], bit_in};
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word   = sr_q;
  assign count  = cnt_q;
  assign commit = latch && (cnt_q == FULL);
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output chan_t             left_q,
  output chan_t             right_q,
  output mode_t             mode_q
);
  dest_e             dest;
  logic [PAY_W-1:0]  payload;

  assign dest    = dest_e'(word[WORD_W-1 -: ADDR_W]);
  assign payload = word[PAY_W-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      left_q  <= CHAN_DEFAULT;
      right_q <= CHAN_DEFAULT;
      mode_q  <= MODE_DEFAULT;
    end else if (commit) begin
      unique case (dest)
        DST_LEFT:  left_q  <= chan_t'(payload);
        DST_RIGHT: right_q <= chan_t'(payload);
        DST_MODE:  mode_q  <= mode_t'(payload[MODE_W-1:0]);
        DST_RSVD:  ;
      endcase
    end
  end
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_clk,
  input  logic             ctl_data,
  input  logic             ctl_latch,
  output logic [VOL_W-1:0] left_vol,
  output logic             left_mute,
  output logic [VOL_W-1:0] right_vol,
  output logic             right_mute,
  output logic [FLD_W-1:0] fmt_sel,
  output logic [FLD_W-1:0] word_len,
  output logic [FLD_W-1:0] rate_sel,
  output logic [FLD_W-1:0] deemph_sel
);
  logic [2:0]        pins_s;
  logic              sclk_rise;
  logic              latch_rise;
  logic [WORD_W-1:0] shift_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              commit;
  chan_t             left_q, right_q;
  mode_t             mode_q;

  cfgp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({ctl_latch, ctl_data, ctl_clk}),
    .sync_out(pins_s)
  );

  cfgp_rise u_sclk_edge  (.clk(clk), .rst(rst), .level(pins_s[0]), .rise(sclk_rise));
  cfgp_rise u_latch_edge (.clk(clk), .rst(rst), .level(pins_s[2]), .rise(latch_rise));

  cfgp_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en(sclk_rise), .bit_in(pins_s[1]), .latch(latch_rise),
    .word(shift_word), .count(bit_cnt), .commit(commit)
  );

  cfgp_regbank u_bank (
    .clk(clk), .rst(rst), .commit(commit), .word(shift_word),
    .left_q(left_q), .right_q(right_q), .mode_q(mode_q)
  );

  assign left_vol   = left_q.vol;
  assign left_mute  = left_q.mute;
  assign right_vol  = right_q.vol;
  assign right_mute = right_q.mute;
  assign fmt_sel    = mode_q.fmt;
  assign word_len   = mode_q.wlen;
  assign rate_sel   = mode_q.rate;
  assign deemph_sel = mode_q.deemph;
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        sclk_rise,
  input logic        latch_rise,
  input logic        data_s,
  input logic [15:0] shift_word,
  input logic [4:0]  bit_cnt,
  input logic        commit,
  input logic [13:0] left_bus,
  input logic [13:0] right_bus,
  input logic [7:0]  mode_bus
);
  // R2: a sampled control-clock edge moves the synchronised data bit into the LSB
  assert_msb_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !latch_rise) |=> (shift_word[0] == $past(data_s)));

  assert_left_only_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(left_bus) |-> $past(commit && shift_word[15:14] == 2'b00));

  assert_right_only_on_commit_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(right_bus) |-> $past(commit && shift_word[15:14] == 2'b01));

  assert_mode_only_on_commit_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_bus) |-> $past(commit && shift_word[15:14] == 2'b10));

  assert_reserved_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (commit && shift_word[15:14] == 2'b11) |=>
      ($stable(left_bus) && $stable(right_bus) && $stable(mode_bus)));

  assert_latch_clears_count_R8: assert property (@(posedge clk) disable iff (rst)
    latch_rise |=> (bit_cnt == 5'd0));

  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= 5'd16);
endmodule

bind cfgp_port cfgp_port_chk u_chk (
  .clk(clk), .rst(rst),
  .sclk_rise(sclk_rise), .latch_rise(latch_rise), .data_s(pins_s[1]),
  .shift_word(shift_word), .bit_cnt(bit_cnt), .commit(commit),
  .left_bus({left_mute, left_vol}), .right_bus({right_mute, right_vol}),
  .mode_bus({deemph_sel, rate_sel, word_len, fmt_sel})
);

// File: tb/test_cfgp_port.sv
module test_cfgp_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_clk = 1'b0, ctl_data = 1'b0, ctl_latch = 1'b0;
  logic [12:0] left_vol, right_vol;
  logic left_mute, right_mute;
  logic [1:0] fmt_sel, word_len, rate_sel, deemph_sel;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cfgp_port i_cfgp_port (
    .clk(clk), .rst(rst), .ctl_clk(ctl_clk), .ctl_data(ctl_data), .ctl_latch(ctl_latch),
    .left_vol(left_vol), .left_mute(left_mute), .right_vol(right_vol), .right_mute(right_mute),
    .fmt_sel(fmt_sel), .word_len(word_len), .rate_sel(rate_sel), .deemph_sel(deemph_sel)
  );

  typedef struct packed {
    logic [15:0] word;
    logic        ml;
    logic [12:0] vl;
    logic        mr;
    logic [12:0] vr;
    logic [7:0]  mode;
  } vec_t;

  // expected = {left mute, left vol, right mute, right vol, {deemph,rate,wlen,fmt}}
  localparam vec_t TBL [7] = '{
    '{16'h0123, 1'b0, 13'h0123, 1'b0, 13'h1FFF, 8'h0D},  // R4
    '{16'h6ABC, 1'b0, 13'h0123, 1'b1, 13'h0ABC, 8'h0D},  // R5
    '{16'h80B6, 1'b0, 13'h0123, 1'b1, 13'h0ABC, 8'hB6},  // R6
    '{16'hFFFF, 1'b0, 13'h0123, 1'b1, 13'h0ABC, 8'hB6},  // R7
    '{16'h3FFF, 1'b1, 13'h1FFF, 1'b1, 13'h0ABC, 8'hB6},  // R4
    '{16'h4000, 1'b1, 13'h1FFF, 1'b0, 13'h0000, 8'hB6},  // R5
    '{16'h8F4D, 1'b1, 13'h1FFF, 1'b0, 13'h0000, 8'h4D}   // R6
  };

  function automatic logic [35:0] observed();
    return {left_mute, left_vol, right_mute, right_vol, deemph_sel, rate_sel, word_len, fmt_sel};
  endfunction

  task automatic check(input string req, input logic [35:0] exp);
    checks++;
    if (observed() !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, observed(), exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] v, input int n, input int gap);
    for (int i = n - 1; i >= 0; i--) begin
      ctl_data = v[i];
      repeat (3) @(negedge clk);
      ctl_clk = 1'b1;
      repeat (gap) @(negedge clk);
      ctl_clk = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic pulse_latch();
    ctl_latch = 1'b1;
    repeat (4) @(negedge clk);
    ctl_latch = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  localparam logic [35:0] DEFS = {1'b0, 13'h1FFF, 1'b0, 13'h1FFF, 8'h0D};

  initial begin
    repeat (3) @(negedge clk);
    check("R1 defaults in reset", DEFS);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 defaults after reset", DEFS);

    // table walk: R2 bit order via asymmetric words
    foreach (TBL[k]) begin
      send_bits({16'h0, TBL[k].word}, 16, 4);
      pulse_latch();
      check($sformatf("R2/R4-R7 vector %0d", k),
            {TBL[k].ml, TBL[k].vl, TBL[k].mr, TBL[k].vr, TBL[k].mode});
    end

    // R3: shifting alone changes nothing, latch alone then commits
    send_bits(32'h0055, 16, 4);
    repeat (8) @(negedge clk);
    check("R3 no change before latch", {1'b1, 13'h1FFF, 1'b0, 13'h0000, 8'h4D});
    pulse_latch();
    check("R3 commit on latch", {1'b0, 13'h0055, 1'b0, 13'h0000, 8'h4D});

    // R8: short words are dropped and count does not carry over
    send_bits(32'h3FF, 10, 4);
    pulse_latch();
    check("R8 short word ignored", {1'b0, 13'h0055, 1'b0, 13'h0000, 8'h4D});
    send_bits(32'h3F, 6, 4);
    pulse_latch();
    check("R8 count cleared by latch", {1'b0, 13'h0055, 1'b0, 13'h0000, 8'h4D});

    // R9: 20 bits, last 16 (16'h7001) used
    send_bits(32'hA7001, 20, 4);
    pulse_latch();
    check("R9 last 16 bits", {1'b0, 13'h0055, 1'b1, 13'h1001, 8'h4D});

    // R10: long gaps in control clock
    send_bits(32'h0200, 16, 150);
    pulse_latch();
    check("R10 gated clock", {1'b0, 13'h0200, 1'b1, 13'h1001, 8'h4D});

    // R11: reset mid-word
    send_bits(32'hFF, 8, 4);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 defaults after mid-word reset", DEFS);
    send_bits(32'h00, 8, 4);
    pulse_latch();
    check("R11 partial word discarded", DEFS);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule